// File: doc/BRIEF.md
# GPIO Controller with Pin Interrupts

This block drives and samples a bank of 32 general-purpose pins. Every pin is set by its direction bit to be either an output, driven from a data register, or an input. Inputs are brought into the clock domain by a two-flop synchronizer before anything looks at them. Software reaches the block over a simple synchronous register bus. A write takes effect on the clock edge where it is presented. A read returns its data, with a valid flag, one cycle after the request.

Each pin can latch an interrupt status bit. The condition for a pin is a 2-bit trigger code: low level, high level, rising edge or falling edge. A separate per-pin any-edge bit overrides that code. Software clears latched status by writing ones. A mask register decides which status bits reach the two interrupt lines. One line serves the lower half of the pins and the other serves the upper half.

Top module: `gpio_irq_ctrl`

## Requirements
- R1: The registers are addressed by word index (byte offset / 4): 0 data, 1 direction, 2 pad status (read-only), 3 trigger config for pins 0..15, 4 trigger config for pins 16..31, 5 mask, 6 interrupt status, 7 any-edge select. Every register resets to zero and reads back what was written.
- R2: `padOe` equals the direction register and `padOut` equals the data register, starting from the cycle after the write.
- R3: A read of the data register returns data-register bits where direction is 1 and synchronized pad bits where direction is 0.
- R4: A pad status read returns the pad inputs after a two-flop synchronizer. A pad change made just before an edge is not visible to a read requested on the following edge, and is visible to a read requested two edges later.
- R5: The 2-bit trigger code selects the status-setting condition: 0 pad low, 1 pad high, 2 rising edge, 3 falling edge, all on the synchronized pad.
- R6: The code of pin i lies at bits [2i+1:2i] of word 3 for i < 16, and at bits [2(i-16)+1:2(i-16)] of word 4 for i >= 16.
- R7: When a pin's any-edge bit (word 7) is 1, both rising and falling edges set its status bit, whatever its code.
- R8: Writing word 6 clears each status bit written as 1 and leaves each bit written as 0 unchanged. Status bits stay set until cleared.
- R9: While a level condition holds, its status bit is set again on every cycle, so a clear does not remove it.
- R10: `irqLow` is the OR of status AND mask over pins 0..15, and `irqHigh` is the same over pins 16..31. Both are low in the cycle after the mask is written to zero.
- R11: `busRvalid` is 1 exactly in the cycle after a read request, and `busRdata` carries the register value as it stood at the request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| busReq | input | 1 | Register access request |
| busWr | input | 1 | 1 = write, 0 = read |
| busWordAddr | input | 3 | Register word index |
| busWdata | input | 32 | Write data |
| busRdata | output | 32 | Read data, valid with busRvalid |
| busRvalid | output | 1 | Read data valid |
| padIn | input | 32 | Pad input levels, asynchronous |
| padOut | output | 32 | Pad output levels |
| padOe | output | 32 | Pad output enables |
| irqLow | output | 1 | Interrupt for pins 0..15 |
| irqHigh | output | 1 | Interrupt for pins 16..31 |

## Verification
A trigger code decoded from the wrong field, or a stale edge-history flop, shows up in the status word read three cycles after a single pin toggles. The bits that appear are then the wrong ones or extra ones. Each of the five trigger modes is swept over every pin and both idle levels for this reason. A wrong clear or wrong masking shows at the interrupt lines in the cycle after the register write. A synchronizer with the wrong depth shows as a pad status read that changes one request too early or too late.

// File: rtl/gpio_irq_pkg.sv
package gpio_irq_pkg;

  localparam logic [1:0] TRIG_LOW  = 2'd0;
  localparam logic [1:0] TRIG_HIGH = 2'd1;
  localparam logic [1:0] TRIG_RISE = 2'd2;
  localparam logic [1:0] TRIG_FALL = 2'd3;

  typedef enum logic [2:0] {
    REG_DATA  = 3'd0,
    REG_DIR   = 3'd1,
    REG_PAD   = 3'd2,
    REG_CFGLO = 3'd3,
    REG_CFGHI = 3'd4,
    REG_MASK  = 3'd5,
    REG_STAT  = 3'd6,
    REG_EDGE  = 3'd7
  } regSel_t;

  typedef struct packed {
    logic    wrData;
    logic    wrDir;
    logic    wrCfgLo;
    logic    wrCfgHi;
    logic    wrMask;
    logic    wrStat;
    logic    wrEdge;
    logic    rdEn;
    regSel_t rdSel;
  } ctlStrobes_t;

endpackage

// File: rtl/gpio_irq_ctrl_sync.sv
module gpio_irq_ctrl_sync #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic [W-1:0] asyncIn,
  output logic [W-1:0] syncOut
);
  logic [W-1:0] stage1;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      stage1  <= '0;
      syncOut <= '0;
    end else begin
      stage1  <= asyncIn;
      syncOut <= stage1;
    end
  end
endmodule

// File: rtl/gpio_irq_ctrl_regctl.sv
module gpio_irq_ctrl_regctl
  import gpio_irq_pkg::*;
(
  input  logic        busReq,
  input  logic        busWr,
  input  logic [2:0]  busWordAddr,
  output ctlStrobes_t stb
);
  regSel_t sel;

  assign sel = regSel_t'(busWordAddr);

  always_comb begin
    stb = '0;
    if (busReq && busWr) begin
      case (sel)
        REG_DATA:  stb.wrData  = 1'b1;
        REG_DIR:   stb.wrDir   = 1'b1;
        REG_CFGLO: stb.wrCfgLo = 1'b1;
        REG_CFGHI: stb.wrCfgHi = 1'b1;
        REG_MASK:  stb.wrMask  = 1'b1;
        REG_STAT:  stb.wrStat  = 1'b1;
        REG_EDGE:  stb.wrEdge  = 1'b1;
        default:   ;
      endcase
    end
    stb.rdEn  = busReq && !busWr;
    stb.rdSel = sel;
  end
endmodule

// File: rtl/gpio_irq_ctrl_datapath.sv
module gpio_irq_ctrl_datapath
  import gpio_irq_pkg::*;
#(
  parameter int NUM_PINS = 32
) (
  input  logic                clk,
  input  logic                rstN,
  input  ctlStrobes_t         stb,
  input  logic [NUM_PINS-1:0] wdata,
  input  logic [NUM_PINS-1:0] padIn,
  output logic [NUM_PINS-1:0] rdata,
  output logic                rvalid,
  output logic [NUM_PINS-1:0] padOut,
  output logic [NUM_PINS-1:0] padOe,
  output logic                irqLow,
  output logic                irqHigh
);
  localparam int HALF = NUM_PINS / 2;

  logic [NUM_PINS-1:0] dataReg, dirReg, cfgLoReg, cfgHiReg;
  logic [NUM_PINS-1:0] maskReg, statReg, edgeReg;
  logic [NUM_PINS-1:0] padSync, padPrev, hit, clrBits, pending, readMux;

  function automatic logic trigHit(input logic [1:0] code, input logic anyEdge,
                                   input logic cur, input logic prev);
    logic rise, fall;
    rise = cur & ~prev;
    fall = ~cur & prev;
    if (anyEdge) return rise | fall;
    case (code)
      TRIG_LOW:  return ~cur;
      TRIG_HIGH: return cur;
      TRIG_RISE: return rise;
      default:   return fall;
    endcase
  endfunction

  gpio_irq_ctrl_sync #(.W(NUM_PINS)) u_sync (
    .clk    (clk),
    .rstN   (rstN),
    .asyncIn(padIn),
    .syncOut(padSync)
  );

  for (genvar i = 0; i < NUM_PINS; i++) begin : g_pin
    if (i < HALF) begin : g_lo
      assign hit[i] = trigHit(cfgLoReg[2*i +: 2], edgeReg[i], padSync[i], padPrev[i]);
    end else begin : g_hi
      assign hit[i] = trigHit(cfgHiReg[2*(i-HALF) +: 2], edgeReg[i], padSync[i], padPrev[i]);
    end
  end

  assign clrBits = stb.wrStat ? wdata : '0;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      dataReg  <= '0;
      dirReg   <= '0;
      cfgLoReg <= '0;
      cfgHiReg <= '0;
      maskReg  <= '0;
      statReg  <= '0;
      edgeReg  <= '0;
      padPrev  <= '0;
    end else begin
      if (stb.wrData)  dataReg  <= wdata;
      if (stb.wrDir)   dirReg   <= wdata;
      if (stb.wrCfgLo) cfgLoReg <= wdata;
      if (stb.wrCfgHi) cfgHiReg <= wdata;
      if (stb.wrMask)  maskReg  <= wdata;
      if (stb.wrEdge)  edgeReg  <= wdata;
      statReg <= (statReg & ~clrBits) | hit;
      padPrev <= padSync;
    end
  end

  always_comb begin
    case (stb.rdSel)
      REG_DATA:  readMux = (dataReg & dirReg) | (padSync & ~dirReg);
      REG_DIR:   readMux = dirReg;
      REG_PAD:   readMux = padSync;
      REG_CFGLO: readMux = cfgLoReg;
      REG_CFGHI: readMux = cfgHiReg;
      REG_MASK:  readMux = maskReg;
      REG_STAT:  readMux = statReg;
      default:   readMux = edgeReg;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      rdata  <= '0;
      rvalid <= 1'b0;
    end else begin
      rdata  <= stb.rdEn ? readMux : '0;
      rvalid <= stb.rdEn;
    end
  end

  assign pending = statReg & maskReg;
  assign irqLow  = |pending[HALF-1:0];
  assign irqHigh = |pending[NUM_PINS-1:HALF];
  assign padOut  = dataReg;
  assign padOe   = dirReg;
endmodule

// File: rtl/gpio_irq_ctrl.sv
module gpio_irq_ctrl
  import gpio_irq_pkg::*;
#(
  parameter int NUM_PINS = 32
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                busReq,
  input  logic                busWr,
  input  logic [2:0]          busWordAddr,
  input  logic [NUM_PINS-1:0] busWdata,
  output logic [NUM_PINS-1:0] busRdata,
  output logic                busRvalid,
  input  logic [NUM_PINS-1:0] padIn,
  output logic [NUM_PINS-1:0] padOut,
  output logic [NUM_PINS-1:0] padOe,
  output logic                irqLow,
  output logic                irqHigh
);
  ctlStrobes_t stb;

  gpio_irq_ctrl_regctl u_ctl (
    .busReq     (busReq),
    .busWr      (busWr),
    .busWordAddr(busWordAddr),
    .stb        (stb)
  );

  gpio_irq_ctrl_datapath #(.NUM_PINS(NUM_PINS)) u_dp (
    .clk    (clk),
    .rstN   (rstN),
    .stb    (stb),
    .wdata  (busWdata),
    .padIn  (padIn),
    .rdata  (busRdata),
    .rvalid (busRvalid),
    .padOut (padOut),
    .padOe  (padOe),
    .irqLow (irqLow),
    .irqHigh(irqHigh)
  );
endmodule

// File: rtl/gpio_irq_ctrl_chk.sv
module gpio_irq_ctrl_chk #(
  parameter int NUM_PINS = 32
) (
  input logic                clk,
  input logic                rstN,
  input logic                busReq,
  input logic                busWr,
  input logic [2:0]          busWordAddr,
  input logic [NUM_PINS-1:0] busWdata,
  input logic [NUM_PINS-1:0] busRdata,
  input logic                busRvalid,
  input logic [NUM_PINS-1:0] padIn,
  input logic [NUM_PINS-1:0] padOut,
  input logic [NUM_PINS-1:0] padOe,
  input logic                irqLow,
  input logic                irqHigh
);
  // R11
  rd_valid_rise_chk: assert property (@(posedge clk) disable iff (!rstN)
    (busReq && !busWr) |=> busRvalid);

  // R11
  rd_valid_idle_chk: assert property (@(posedge clk) disable iff (!rstN)
    !(busReq && !busWr) |=> !busRvalid);

  // R2
  dir_to_oe_chk: assert property (@(posedge clk) disable iff (!rstN)
    (busReq && busWr && busWordAddr == 3'd1) |=> (padOe == $past(busWdata)));

  // R2
  data_to_out_chk: assert property (@(posedge clk) disable iff (!rstN)
    (busReq && busWr && busWordAddr == 3'd0) |=> (padOut == $past(busWdata)));

  // R10
  mask_off_quiet_chk: assert property (@(posedge clk) disable iff (!rstN)
    (busReq && busWr && busWordAddr == 3'd5 && busWdata == '0) |=> (!irqLow && !irqHigh));

  // R4
  pad_sync_depth_chk: assert property (@(posedge clk) disable iff (!rstN)
    (busReq && !busWr && busWordAddr == 3'd2) |=> (busRdata == $past(padIn, 3)));
endmodule

bind gpio_irq_ctrl gpio_irq_ctrl_chk #(.NUM_PINS(NUM_PINS)) u_chk (
  .clk        (clk),
  .rstN       (rstN),
  .busReq     (busReq),
  .busWr      (busWr),
  .busWordAddr(busWordAddr),
  .busWdata   (busWdata),
  .busRdata   (busRdata),
  .busRvalid  (busRvalid),
  .padIn      (padIn),
  .padOut     (padOut),
  .padOe      (padOe),
  .irqLow     (irqLow),
  .irqHigh    (irqHigh)
);

// File: tb/gpio_irq_ctrl_tb.sv
module gpio_irq_ctrl_tb;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        busReq = 1'b0;
  logic        busWr = 1'b0;
  logic [2:0]  busWordAddr = '0;
  logic [31:0] busWdata = '0;
  logic [31:0] busRdata;
  logic        busRvalid;
  logic [31:0] padIn = '0;
  logic [31:0] padOut, padOe;
  logic        irqLow, irqHigh;

  int nChecks = 0;
  int nFail = 0;

  always #4 clk = ~clk;

  gpio_irq_ctrl u_dut (
    .clk(clk), .rstN(rstN), .busReq(busReq), .busWr(busWr),
    .busWordAddr(busWordAddr), .busWdata(busWdata), .busRdata(busRdata),
    .busRvalid(busRvalid), .padIn(padIn), .padOut(padOut), .padOe(padOe),
    .irqLow(irqLow), .irqHigh(irqHigh)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic busWrite(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk);
    busReq = 1'b1; busWr = 1'b1; busWordAddr = a; busWdata = d;
    @(negedge clk);
    busReq = 1'b0; busWr = 1'b0;
  endtask

  task automatic busRead(input logic [2:0] a, output logic [31:0] d);
    @(negedge clk);
    busReq = 1'b1; busWr = 1'b0; busWordAddr = a;
    @(posedge clk);
    #1;
    d = busRdata;
    check("R11 rvalid after request", {31'b0, busRvalid}, 32'd1);
    @(negedge clk);
    busReq = 1'b0;
  endtask

  task automatic setPad(input logic [31:0] v);
    @(negedge clk);
    padIn = v;
    repeat (3) @(negedge clk);
  endtask

  function automatic logic [31:0] events(input int mode, input logic [31:0] oldV,
                                         input logic [31:0] newV);
    case (mode)
      0: return ~newV;
      1: return newV;
      2: return newV & ~oldV;
      3: return ~newV & oldV;
      default: return newV ^ oldV;
    endcase
  endfunction

  function automatic logic [31:0] levelBits(input int mode, input logic [31:0] v);
    if (mode == 0) return ~v;
    if (mode == 1) return v;
    return 32'h0;
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    nFail++;
    $display("FAIL watchdog expired");
    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFail);
    $finish;
  end

  initial begin
    logic [31:0] rd, pad, nxt, expStat;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);

    // R1 reset values, R10 and R11 idle outputs
    check("R11 rvalid idle", {31'b0, busRvalid}, 32'd0);
    check("R10 irqLow reset", {31'b0, irqLow}, 32'd0);
    check("R10 irqHigh reset", {31'b0, irqHigh}, 32'd0);
    check("R2 padOe reset", padOe, 32'h0);
    for (int w = 0; w < 8; w++) begin
      if (w != 6) begin
        busRead(w[2:0], rd);
        check("R1 reset read", rd, 32'h0);
      end
    end
    @(negedge clk);
    check("R11 rvalid drops", {31'b0, busRvalid}, 32'd0);

    // R1 readback of writable registers
    busWrite(3'd3, 32'h1234_ABCD); busRead(3'd3, rd); check("R1 cfg-low readback", rd, 32'h1234_ABCD);
    busWrite(3'd4, 32'hCAFE_0042); busRead(3'd4, rd); check("R1 cfg-high readback", rd, 32'hCAFE_0042);
    busWrite(3'd7, 32'h0F0F_1111); busRead(3'd7, rd); check("R1 edge readback", rd, 32'h0F0F_1111);
    busWrite(3'd5, 32'h8000_0001); busRead(3'd5, rd); check("R1 mask readback", rd, 32'h8000_0001);
    busWrite(3'd5, 32'h0);
    busWrite(3'd7, 32'h0);

    // R2 outputs, R3 data view, R4 pad status
    busWrite(3'd1, 32'hFFFF_0000);
    check("R2 padOe", padOe, 32'hFFFF_0000);
    busWrite(3'd0, 32'hA5A5_A5A5);
    check("R2 padOut", padOut, 32'hA5A5_A5A5);
    busRead(3'd1, rd); check("R1 dir readback", rd, 32'hFFFF_0000);
    setPad(32'h1234_5678);
    busRead(3'd0, rd); check("R3 data mixed view", rd, 32'hA5A5_5678);
    busRead(3'd2, rd); check("R4 pad status", rd, 32'h1234_5678);
    @(negedge clk);
    padIn = 32'h0BAD_F00D;
    busRead(3'd2, rd); check("R4 sync not yet visible", rd, 32'h1234_5678);
    busRead(3'd2, rd); check("R4 sync visible", rd, 32'h0BAD_F00D);
    busWrite(3'd1, 32'h0);
    busRead(3'd0, rd); check("R3 all-input data view", rd, 32'h0BAD_F00D);

    // R5 R7 sweep: every mode, both idle levels, every pin
    for (int mode = 0; mode < 5; mode++) begin
      logic [1:0] code;
      code = (mode == 4) ? 2'd3 : mode[1:0];
      busWrite(3'd3, {16{code}});
      busWrite(3'd4, {16{code}});
      busWrite(3'd7, (mode == 4) ? 32'hFFFF_FFFF : 32'h0);
      for (int idle = 0; idle < 2; idle++) begin
        pad = (idle == 1) ? 32'hFFFF_FFFF : 32'h0;
        setPad(pad);
        for (int p = 0; p < 32; p++) begin
          busWrite(3'd6, 32'hFFFF_FFFF);
          expStat = levelBits(mode, pad);
          busRead(3'd6, rd);
          check((mode < 2) ? "R9 level after clear" : "R8 edge status cleared", rd, expStat);
          nxt = pad ^ (32'h1 << p);
          setPad(nxt);
          expStat |= events(mode, pad, nxt);
          busRead(3'd6, rd);
          check((mode == 4) ? "R7 any-edge first toggle" : "R5 code first toggle", rd, expStat);
          setPad(pad);
          expStat |= events(mode, nxt, pad);
          busRead(3'd6, rd);
          check((mode == 4) ? "R7 any-edge second toggle" : "R5 code second toggle", rd, expStat);
        end
      end
    end

    // R6 field placement: low half rising, high half falling
    busWrite(3'd7, 32'h0);
    busWrite(3'd3, {16{2'd2}});
    busWrite(3'd4, {16{2'd3}});
    setPad(32'h0);
    busWrite(3'd6, 32'hFFFF_FFFF);
    setPad(32'h0010_0008);
    busRead(3'd6, rd); check("R6 rise only in low half", rd, 32'h0000_0008);
    setPad(32'h0);
    busRead(3'd6, rd); check("R6 fall only in high half", rd, 32'h0010_0008);

    // R8 write-one-to-clear
    busWrite(3'd6, 32'h0);
    busRead(3'd6, rd); check("R8 zero write keeps", rd, 32'h0010_0008);
    busWrite(3'd6, 32'h0000_0008);
    busRead(3'd6, rd); check("R8 one write clears bit", rd, 32'h0010_0000);

    // R10 mask and half split, every pin
    busWrite(3'd3, {16{2'd2}});
    busWrite(3'd4, {16{2'd2}});
    for (int p = 0; p < 32; p++) begin
      busWrite(3'd6, 32'hFFFF_FFFF);
      setPad(32'h1 << p);
      busWrite(3'd5, 32'h1 << p);
      check("R10 irqLow masked on", {31'b0, irqLow}, {31'b0, (p < 16)});
      check("R10 irqHigh masked on", {31'b0, irqHigh}, {31'b0, (p >= 16)});
      busWrite(3'd5, ~(32'h1 << p));
      check("R10 other bits masked", {31'b0, irqLow | irqHigh}, 32'd0);
      busWrite(3'd5, 32'h0);
      setPad(32'h0);
    end

    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFail);
    $finish;
  end
endmodule